// File: doc/BRIEF.md
# Two-Port Memory with Low-Address Register Overlay

This block fronts a small two-port RAM and, while an active-low overlay select is held low, takes over the two lowest word addresses. Word 0 becomes a read-only view of two external status pins. Those pins pass through a two-stage synchronizer before they can be read. Word 1 becomes a five-bit output control register. Each bit drives one external switch, with 1 meaning on. Both ports reach the same register, so either one can change the outputs or read them back. While the select is high, words 0 and 1 are ordinary RAM words like all the others.

Each port is a plain synchronous bus with chip enable, write enable, address, write data and read data. A read (ce high, we low) is taken at a rising clock edge. Its data appears on the port's read bus after that edge and stays there until the port issues its next read. There is no back-pressure: every access issued in a cycle completes in that cycle. A read returns the contents as they were before any write taken at the same edge. If both ports write the same target at the same edge, the left port's data is kept.

Top module: `spo_overlay`

## Requirements
- R1: After reset both read buses are zero and all five drive outputs are zero (off).
- R2: With the overlay selected (ovl_sel_n low), a read of word 0 returns the synchronized pin levels in bits 1:0 and zero in every higher bit.
- R3: With the overlay selected, writes to word 0 from either port change nothing: neither the status view nor the RAM word 0 that reappears once the overlay is released.
- R4: With the overlay selected, a write to word 1 from either port loads write-data bits 4:0 into the drive register and ignores the higher bits. drive_on shows the register after the edge, and a read of word 1 from either port returns it zero-extended.
- R5: When both ports write word 1 at the same edge with the overlay selected, the left port's value is kept.
- R6: With the overlay released (ovl_sel_n high), words 0 and 1 store and return data like any other word, and writes to them leave drive_on unchanged.
- R7: An ordinary RAM read returns the word on the read bus one edge after it is taken. When the other port writes the same word at that edge, the read returns the value from before the write.
- R8: When both ports write the same RAM word at the same edge, the left port's data is stored.
- R9: A port's read bus holds its last value in every cycle in which that port issues no read.
- R10: A change on the status pins becomes readable only through the third read edge after the change. Reads taken at the first and second edges still return the previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_sel_n | input | 1 | Active-low overlay select for words 0 and 1 |
| stat_pins | input | 2 | Asynchronous external status inputs |
| drive_on | output | 5 | Output switch controls, 1 = on |
| l_ce | input | 1 | Left port chip enable |
| l_we | input | 1 | Left port write enable |
| l_addr | input | 6 | Left port word address |
| l_wdata | input | 16 | Left port write data |
| l_rdata | output | 16 | Left port read data |
| r_ce | input | 1 | Right port chip enable |
| r_we | input | 1 | Right port write enable |
| r_addr | input | 6 | Right port word address |
| r_wdata | input | 16 | Right port write data |
| r_rdata | output | 16 | Right port read data |

## Verification
The bench tests a blocked write to word 0 by releasing the overlay afterwards and reading the RAM word underneath. A decoder that let the write through would corrupt that word. It loads the drive register with data whose upper bits are set, and issues same-edge writes from both ports to the register and to a RAM word. A wrong width or reversed priority would show the wrong value or let the right port win. It also times status-pin changes against reads at each of the first three edges after the change. It interleaves these directed cases with random traffic that flips the overlay select, so that a missing gate on the select would show up as drive outputs changing in plain-RAM mode.

// File: rtl/spo_pkg.sv
package spo_pkg;
  typedef enum logic [1:0] {
    RG_MEM = 2'd0,
    RG_STAT = 2'd1,
    RG_DRV = 2'd2
  } region_e;

  localparam int unsigned STAT_WORD = 0;
  localparam int unsigned DRV_WORD = 1;
  localparam int unsigned NPORT = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
endpackage

// File: rtl/spo_sync.sv
module spo_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/spo_mem.sv
module spo_mem #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wd_l,
  output logic [DW-1:0] rd_l,
  input  logic          wr_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wd_r,
  output logic [DW-1:0] rd_r
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Right port is applied first so the left port overrides on a collision.
  always_ff @(posedge clk) begin
    if (wr_r) store[addr_r] <= wd_r;
    if (wr_l) store[addr_l] <= wd_l;
  end

  assign rd_l = store[addr_l];
  assign rd_r = store[addr_r];

  AST_MEM_LEFT_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_l && wr_r && addr_l == addr_r) |=> (store[$past(addr_l)] == $past(wd_l))) // R8
    else $error("left port lost a same-word write collision");
endmodule

// File: rtl/spo_drv_reg.sv
module spo_drv_reg #(
  parameter int unsigned OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_l,
  input  logic [OW-1:0] wd_l,
  input  logic          wr_r,
  input  logic [OW-1:0] wd_r,
  output logic [OW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_l) q <= wd_l;
    else if (wr_r) q <= wd_r;
  end

  AST_DRV_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(wr_l || wr_r)) // R4
    else $error("drive register changed without a write");

  AST_DRV_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_l && wr_r) |=> (q == $past(wd_l))) // R5
    else $error("drive register took the right port on a collision");
endmodule

// File: rtl/spo_overlay.sv
module spo_overlay
  import spo_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16,
  parameter int unsigned IN_W = 2,
  parameter int unsigned OUT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovl_sel_n,
  input  logic [IN_W-1:0]  stat_pins,
  output logic [OUT_W-1:0] drive_on,
  input  logic             l_ce,
  input  logic             l_we,
  input  logic [AW-1:0]    l_addr,
  input  logic [DW-1:0]    l_wdata,
  output logic [DW-1:0]    l_rdata,
  input  logic             r_ce,
  input  logic             r_we,
  input  logic [AW-1:0]    r_addr,
  input  logic [DW-1:0]    r_wdata,
  output logic [DW-1:0]    r_rdata
);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_WORD);
  localparam logic [AW-1:0] DRV_A  = AW'(DRV_WORD);

  logic [NPORT-1:0] ce, we, rd, mem_wr, drv_wr;
  logic [AW-1:0]    addr    [NPORT];
  logic [DW-1:0]    wdata   [NPORT];
  logic [DW-1:0]    mem_rd  [NPORT];
  logic [DW-1:0]    rdata_q [NPORT];
  region_e          region  [NPORT];
  logic [IN_W-1:0]  stat_sync;
  logic [OUT_W-1:0] drv_q;

  assign ce[PORT_L] = l_ce;  assign we[PORT_L] = l_we;
  assign ce[PORT_R] = r_ce;  assign we[PORT_R] = r_we;
  assign addr[PORT_L]  = l_addr;  assign addr[PORT_R]  = r_addr;
  assign wdata[PORT_L] = l_wdata; assign wdata[PORT_R] = r_wdata;

  spo_sync #(.W(IN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(stat_pins), .sync_out(stat_sync)
  );

  spo_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_l(mem_wr[PORT_L]), .addr_l(addr[PORT_L]), .wd_l(wdata[PORT_L]), .rd_l(mem_rd[PORT_L]),
    .wr_r(mem_wr[PORT_R]), .addr_r(addr[PORT_R]), .wd_r(wdata[PORT_R]), .rd_r(mem_rd[PORT_R])
  );

  spo_drv_reg #(.OW(OUT_W)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .wr_l(drv_wr[PORT_L]), .wd_l(wdata[PORT_L][OUT_W-1:0]),
    .wr_r(drv_wr[PORT_R]), .wd_r(wdata[PORT_R][OUT_W-1:0]),
    .q(drv_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      region[p] = RG_MEM;
      if (!ovl_sel_n && addr[p] == STAT_A) region[p] = RG_STAT;
      else if (!ovl_sel_n && addr[p] == DRV_A) region[p] = RG_DRV;
    end

    assign rd[p]     = ce[p] && !we[p];
    assign mem_wr[p] = ce[p] && we[p] && (region[p] == RG_MEM);
    assign drv_wr[p] = ce[p] && we[p] && (region[p] == RG_DRV);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q[p] <= '0;
      else if (rd[p]) begin
        unique case (region[p])
          RG_STAT: rdata_q[p] <= DW'(stat_sync);
          RG_DRV:  rdata_q[p] <= DW'(drv_q);
          default: rdata_q[p] <= mem_rd[p];
        endcase
      end
    end

    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd[p] && region[p] == RG_STAT) |=> (rdata_q[p][DW-1:IN_W] == '0)) // R2
      else $error("status read returned nonzero upper bits");

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd[p] |=> $stable(rdata_q[p])) // R9
      else $error("read bus moved without a read");
  end

  AST_PLAIN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_sel_n && !(l_ce && l_we && !ovl_sel_n)) |=> $stable(drv_q)) // R6
    else $error("drive outputs changed with overlay released");

  assign l_rdata  = rdata_q[PORT_L];
  assign r_rdata  = rdata_q[PORT_R];
  assign drive_on = drv_q;
endmodule

// File: tb/tb_spo_overlay.sv
module tb_spo_overlay;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovl_sel_n = 1'b1;
  logic [1:0] stat_pins = '0;
  logic [4:0] drive_on;
  logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;

  always #10 clk = ~clk;

  spo_overlay dut (
    .clk(clk), .rst_n(rst_n), .ovl_sel_n(ovl_sel_n), .stat_pins(stat_pins),
    .drive_on(drive_on),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [4:0]    m_drv = '0;
  logic [1:0]    m_s1 = '0, m_s2 = '0;
  logic [DW-1:0] exp_l = '0, exp_r = '0;
  logic          sel_b = 1'b1;
  logic [1:0]    pins_b = '0;

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    if (!sel_b && a == 0) return DW'(m_s2);
    if (!sel_b && a == 1) return DW'(m_drv);
    return m_mem[a];
  endfunction

  function automatic string auto_tag(input logic ce, input logic we, input logic [AW-1:0] a);
    if (!(ce && !we)) return "R9";
    if (!sel_b && a == 0) return "R2";
    if (!sel_b && a == 1) return "R4";
    if (a < 2) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic lce, input logic lwe, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                      input logic rce, input logic rwe, input logic [AW-1:0] ra, input logic [DW-1:0] rdv,
                      input string tag);
    string tl, tr, td;
    @(negedge clk);
    ovl_sel_n = sel_b; stat_pins = pins_b;
    l_ce = lce; l_we = lwe; l_addr = la; l_wdata = ld;
    r_ce = rce; r_we = rwe; r_addr = ra; r_wdata = rdv;
    tl = (tag != "") ? tag : auto_tag(lce, lwe, la);
    tr = (tag != "") ? tag : auto_tag(rce, rwe, ra);
    td = (tag != "") ? tag : (sel_b ? "R6" : "R4");
    @(posedge clk);
    if (lce && !lwe) exp_l = model_read(la);
    if (rce && !rwe) exp_r = model_read(ra);
    m_s2 = m_s1; m_s1 = pins_b;
    if (rce && rwe) begin
      if (!sel_b && ra == 1) m_drv = rdv[4:0];
      else if (sel_b || ra > 1) m_mem[ra] = rdv;
    end
    if (lce && lwe) begin
      if (!sel_b && la == 1) m_drv = ld[4:0];
      else if (sel_b || la > 1) m_mem[la] = ld;
    end
    #5;
    check(tl, "left read bus", l_rdata, exp_l);
    check(tr, "right read bus", r_rdata, exp_r);
    check(td, "drive outputs", DW'(drive_on), DW'(m_drv));
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, '0, 0, 0, '0, '0, tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    #5;
    check("R1", "reset left read", l_rdata, '0);
    check("R1", "reset right read", r_rdata, '0);
    check("R1", "reset drive", DW'(drive_on), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill RAM with overlay released; words 0 and 1 are plain (R6)
    sel_b = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(1, 1, AW'(i), 16'hA5C3 ^ DW'(i * 257), 0, 0, '0, '0, "");
    step(0, 0, '0, '0, 1, 0, 6'd0, '0, "R6");
    step(1, 0, 6'd1, '0, 0, 0, '0, '0, "R6");

    // Blocked write to word 0 under overlay, then look underneath (R3)
    sel_b = 1'b0;
    step(1, 1, 6'd0, 16'hFFFF, 1, 1, 6'd0, 16'h1234, "R3");
    step(1, 0, 6'd0, '0, 0, 0, '0, '0, "R3");
    sel_b = 1'b1;
    step(0, 0, '0, '0, 1, 0, 6'd0, '0, "R3");

    // Drive register: upper bits dropped, read back from the other port (R4)
    sel_b = 1'b0;
    step(0, 0, '0, '0, 1, 1, 6'd1, 16'hFFEA, "R4");
    step(1, 0, 6'd1, '0, 1, 0, 6'd1, '0, "R4");
    // Same-edge writes to the drive register (R5)
    step(1, 1, 6'd1, 16'h0003, 1, 1, 6'd1, 16'h001C, "R5");
    step(0, 0, '0, '0, 1, 0, 6'd1, '0, "R5");

    // Status pin timing (R10)
    pins_b = 2'b10;
    step(1, 0, 6'd0, '0, 0, 0, '0, '0, "R10");
    step(1, 0, 6'd0, '0, 0, 0, '0, '0, "R10");
    step(1, 0, 6'd0, '0, 1, 0, 6'd0, '0, "R10");

    // RAM collision and read-before-write (R8, R7)
    step(1, 1, 6'd20, 16'hBEEF, 1, 1, 6'd20, 16'hDEAD, "R8");
    step(0, 0, '0, '0, 1, 0, 6'd20, '0, "R8");
    step(1, 1, 6'd30, 16'h7777, 1, 0, 6'd30, '0, "R7");
    step(0, 0, '0, '0, 1, 0, 6'd30, '0, "R7");
    // Hold with no reads (R9)
    idle("R9");
    idle("R9");

    // Released overlay: writes to word 1 leave drive outputs alone (R6)
    sel_b = 1'b1;
    step(1, 1, 6'd1, 16'h001F, 0, 0, '0, '0, "R6");
    step(0, 0, '0, '0, 1, 0, 6'd1, '0, "R6");

    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] la, ra;
      if (($urandom % 8) == 0) sel_b = ~sel_b;
      if (($urandom % 5) == 0) pins_b = 2'($urandom);
      la = (($urandom % 3) == 0) ? AW'($urandom % 2) : AW'($urandom);
      ra = (($urandom % 3) == 0) ? AW'($urandom % 2) : AW'($urandom);
      step(1'($urandom), 1'($urandom), la, 16'($urandom),
           1'($urandom), 1'($urandom), ra, 16'($urandom), "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule